// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous page-mode DRAM with 2048 internally counted rows alive. It runs from the system clock. All timing figures are given in nanoseconds and turned into clock counts when the design is elaborated. After reset it waits out the power-up pause. It then runs a burst of initialisation refreshes and raises `init_done`. From then on it asks for one refresh per refresh interval. Each refresh is a CAS-before-RAS cycle: CAS# falls first, RAS# follows, and the DRAM's internal row counter picks the row. The block therefore never drives a row address.

The DRAM strobes are shared with an access sequencer through a four-phase request/grant handshake. The scheduler raises `ref_req` only while `ref_gnt` is low. It drives the strobes, with `strobe_en` high, only after the grant arrives. It keeps `ref_req` high until the trailing RAS# precharge of its last refresh has finished. It then drops `ref_req` and `strobe_en` together, and the sequencer takes the grant back. Refresh intervals that pass while the grant is withheld are counted, up to a cap. Once the grant returns, they are issued back-to-back. While the scheduler owns the strobes, WE# stays high, so no data ever moves.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, and on the first sample after it, `ref_req`, `strobe_en` and `init_done` are 0 and `ras_n`, `cas_n`, `we_n` are 1.
- R2: The first `ref_req` rise comes no earlier than ceil(PWRUP_NS/CLK_NS) cycles after reset release, and at most 4 cycles later than that.
- R3: In every refresh, CAS# (`cas_n`=0) is low for exactly ceil(T_CSR_NS/CLK_NS) cycles before RAS# (`ras_n`) falls. CAS# then stays low for exactly ceil(T_CHR_NS/CLK_NS) cycles of the RAS# low time.
- R4: RAS# is low for exactly ceil(T_RAS_NS/CLK_NS) cycles. Between two refreshes of one burst, RAS# is high for exactly P + C cycles. Here C is the CAS setup count from R3, and P = max(ceil(T_RP_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) − RAS count − C, 1).
- R5: `we_n` is 1 in every cycle.
- R6: While `strobe_en` is 0, `ras_n` and `cas_n` are 1. `strobe_en` is 1 only while `ref_gnt` is 1.
- R7: `ref_req` rises only while `ref_gnt` is 0. `ref_req` falls in the same cycle as `strobe_en`.
- R8: After power-up, exactly INIT_REFS refreshes are issued back-to-back as one burst. `init_done` rises in the cycle RAS# rises at the end of the last of them.
- R9: After `init_done`, with the grant given promptly, one refresh is issued per floor(INTERVAL_NS/CLK_NS) cycles.
- R10: Intervals that pass while the grant is withheld are counted and then served back-to-back in one burst. At most BACKLOG_MAX are kept, and the rest are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Grant of the DRAM strobes from the access sequencer |
| ref_req | output | 1 | Request for the DRAM strobes |
| strobe_en | output | 1 | High while this block drives RAS#, CAS# and WE# |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| init_done | output | 1 | Power-up pause and initialisation refreshes complete |

## Verification
The bench goes after strobe ordering. If CAS# fell with or after RAS#, the DRAM would see an ordinary row activation and refresh nothing, so the exact setup and hold counts are measured at every RAS# edge. It withholds the grant across three intervals and then across twelve. A scheduler that forgot missed intervals would issue one refresh, and one without a cap would issue twelve. Either wrong count is caught by comparing the size of the next burst. It also checks that the request is never raised against a stale grant, and that the strobes are released in the same cycle as the request. If either failed, the scheduler and the access sequencer would drive the DRAM at the same time.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_CSR,
    ST_ACT
  } cbr_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int N_PWR = 20000,
  parameter int N_INT = 3120
) (
  input  logic clk,
  input  logic rst,
  input  logic init_done,
  output logic pwrup_done,
  output logic tick
);
  localparam int PWW = $clog2(N_PWR + 1);
  localparam int IW  = $clog2(N_INT + 1);

  logic [PWW-1:0] pw_cnt;
  logic [IW-1:0]  int_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pw_cnt     <= '0;
      pwrup_done <= 1'b0;
    end else if (!pwrup_done) begin
      pw_cnt <= pw_cnt + 1'b1;
      if (pw_cnt == PWW'(N_PWR - 1)) pwrup_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !init_done) begin
      int_cnt <= '0;
    end else if (int_cnt == IW'(N_INT - 1)) begin
      int_cnt <= '0;
    end else begin
      int_cnt <= int_cnt + 1'b1;
    end
  end

  assign tick = init_done && (int_cnt == IW'(N_INT - 1));

  assert_pwrup_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    pwrup_done |=> pwrup_done);
  assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int INIT_REFS   = 8,
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrup_done,
  input  logic tick,
  input  logic ref_done,
  output logic pending_nz,
  output logic init_done
);
  localparam int CNT_MAX = (INIT_REFS > BACKLOG_MAX) ? INIT_REFS : BACKLOG_MAX;
  localparam int PW      = $clog2(CNT_MAX + 1);

  logic [PW-1:0] pending;
  logic [PW-1:0] init_left;
  logic          loaded;
  logic          inc;

  assign inc = tick && (pending < PW'(BACKLOG_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      init_left <= '0;
      loaded    <= 1'b0;
      init_done <= 1'b0;
    end else if (pwrup_done && !loaded) begin
      pending   <= PW'(INIT_REFS);
      init_left <= PW'(INIT_REFS);
      loaded    <= 1'b1;
    end else begin
      if (inc && !ref_done)      pending <= pending + 1'b1;
      else if (!inc && ref_done) pending <= pending - 1'b1;
      if (ref_done && !init_done) begin
        init_left <= init_left - 1'b1;
        if (init_left == PW'(1)) init_done <= 1'b1;
      end
    end
  end

  assign pending_nz = (pending != '0);

  assert_backlog_cap_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (pending <= PW'(BACKLOG_MAX)));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    ref_done |-> pending_nz);
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import dram_ref_pkg::*;
#(
  parameter int N_PRE = 8,
  parameter int N_CSR = 2,
  parameter int N_CHR = 2,
  parameter int N_RAS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic pending_nz,
  input  logic ref_gnt,
  output logic ref_done,
  output logic ref_req,
  output logic strobe_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int MAXN = max2(max2(N_PRE, N_CSR), max2(N_CHR, N_RAS));
  localparam int CW   = $clog2(MAXN + 1);

  cbr_state_t    state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          req_d;

  always_comb begin
    state_d  = state;
    cnt_d    = cnt;
    ref_done = 1'b0;
    unique case (state)
      ST_IDLE: if (ref_req && ref_gnt) begin
        state_d = ST_PRE;
        cnt_d   = '0;
      end
      ST_PRE: begin
        if (cnt == CW'(N_PRE - 1)) begin
          state_d = pending_nz ? ST_CSR : ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end
      ST_CSR: begin
        if (cnt == CW'(N_CSR - 1)) begin
          state_d = ST_ACT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end
      ST_ACT: begin
        if (cnt == CW'(N_RAS - 1)) begin
          state_d  = ST_PRE;
          cnt_d    = '0;
          ref_done = 1'b1;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (state == ST_IDLE && state_d == ST_IDLE)
      req_d = ref_req || (pending_nz && !ref_gnt);
    else
      req_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ref_req   <= 1'b0;
      strobe_en <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
    end else begin
      state     <= state_d;
      cnt       <= cnt_d;
      ref_req   <= req_d;
      strobe_en <= (state_d != ST_IDLE);
      ras_n     <= (state_d != ST_ACT);
      cas_n     <= !((state_d == ST_CSR) ||
                     ((state_d == ST_ACT) && (cnt_d < CW'(N_CHR))));
    end
  end

  assign we_n = 1'b1;

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  assert_grant_before_drive_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_en) |-> $past(ref_gnt));
  assert_done_ends_ras_R4: assert property (@(posedge clk) disable iff (rst)
    ref_done |=> $rose(ras_n));
  assert_req_on_free_bus_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_req) |-> !$past(ref_gnt));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int PWRUP_NS    = 100000,
  parameter int INTERVAL_NS = 15600,
  parameter int INIT_REFS   = 8,
  parameter int BACKLOG_MAX = 8,
  parameter int T_CSR_NS    = 10,
  parameter int T_CHR_NS    = 10,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_RC_NS     = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt,
  output logic ref_req,
  output logic strobe_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done
);
  localparam int N_PWR = max2(ceil_div(PWRUP_NS, CLK_NS), 1);
  localparam int N_INT = max2(INTERVAL_NS / CLK_NS, 2);
  localparam int N_CSR = max2(ceil_div(T_CSR_NS, CLK_NS), 1);
  localparam int N_CHR = max2(ceil_div(T_CHR_NS, CLK_NS), 1);
  localparam int N_RAS = max2(ceil_div(T_RAS_NS, CLK_NS), N_CHR + 1);
  localparam int N_RP  = ceil_div(T_RP_NS, CLK_NS);
  localparam int N_RC  = ceil_div(T_RC_NS, CLK_NS);
  localparam int N_PRE = max2(max2(N_RP, N_RC - N_RAS - N_CSR), 1);

  logic pwrup_done;
  logic tick;
  logic pending_nz;
  logic ref_done;

  ref_interval_timer #(
    .N_PWR(N_PWR),
    .N_INT(N_INT)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .init_done (init_done),
    .pwrup_done(pwrup_done),
    .tick      (tick)
  );

  ref_backlog #(
    .INIT_REFS  (INIT_REFS),
    .BACKLOG_MAX(BACKLOG_MAX)
  ) u_backlog (
    .clk       (clk),
    .rst       (rst),
    .pwrup_done(pwrup_done),
    .tick      (tick),
    .ref_done  (ref_done),
    .pending_nz(pending_nz),
    .init_done (init_done)
  );

  cbr_strobe_seq #(
    .N_PRE(N_PRE),
    .N_CSR(N_CSR),
    .N_CHR(N_CHR),
    .N_RAS(N_RAS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pending_nz(pending_nz),
    .ref_gnt   (ref_gnt),
    .ref_done  (ref_done),
    .ref_req   (ref_req),
    .strobe_en (strobe_en),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n)
  );

  assert_init_at_ras_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $rose(ras_n));
  assert_no_req_before_pwrup_R2: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> pwrup_done);
endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int CLK_NS   = 5;
  localparam int PWRUP_NS = 2000;
  localparam int INTV_NS  = 1500;
  localparam int INITN    = 8;
  localparam int BMAX     = 8;

  // expected counts, worked out from the requirement text
  localparam int E_PWR = (PWRUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_INT = INTV_NS / CLK_NS;
  localparam int E_CSR = (10 + CLK_NS - 1) / CLK_NS;
  localparam int E_CHR = (10 + CLK_NS - 1) / CLK_NS;
  localparam int E_RAS = (60 + CLK_NS - 1) / CLK_NS;
  localparam int E_RP  = (40 + CLK_NS - 1) / CLK_NS;
  localparam int E_RC  = (110 + CLK_NS - 1) / CLK_NS;
  localparam int E_P0  = (E_RP > E_RC - E_RAS - E_CSR) ? E_RP : E_RC - E_RAS - E_CSR;
  localparam int E_PRE = (E_P0 < 1) ? 1 : E_P0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req, strobe_en, ras_n, cas_n, we_n, init_done;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_NS(CLK_NS), .PWRUP_NS(PWRUP_NS), .INTERVAL_NS(INTV_NS),
    .INIT_REFS(INITN), .BACKLOG_MAX(BMAX)
  ) u_dram_refresh_sched (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .strobe_en(strobe_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .init_done(init_done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int refs = 0;
  int burst_refs = 0;
  int last_burst = 0;
  int bursts_done = 0;
  int cas_low_run = 0;
  int ras_low_run = 0;
  int ras_high_run = 0;
  int cas_in_ras = 0;
  int gdly = 0;
  bit allow = 1'b1;
  bit seen_req = 1'b0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, prev_req = 1'b0, prev_en = 1'b0, prev_init = 1'b0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  // per-clock reference checks and access-sequencer model
  always @(negedge clk) begin
    if (rst) begin
      chk(!ref_req && !strobe_en && !init_done && ras_n && cas_n && we_n, "R1 reset",
          {ref_req, strobe_en, init_done, ras_n, cas_n, we_n}, 6'b000111);
    end else begin
      cyc++;
      if (cyc == 1)
        chk(!ref_req && !strobe_en && !init_done && ras_n && cas_n, "R1 first",
            {ref_req, strobe_en, init_done, ras_n, cas_n}, 5'b00011);
      chk(we_n == 1'b1, "R5 we_n", we_n, 1);
      if (!strobe_en) chk(ras_n && cas_n, "R6 released strobes", {ras_n, cas_n}, 2'b11);
      else            chk(ref_gnt, "R6 drive needs grant", ref_gnt, 1);
      if (ref_req && !prev_req) begin
        chk(!ref_gnt, "R7 req on free bus", ref_gnt, 0);
        if (!seen_req) begin
          chk(cyc >= E_PWR && cyc <= E_PWR + 4, "R2 power-up pause", cyc, E_PWR);
          seen_req = 1'b1;
        end
      end
      if (prev_req && !ref_req) begin
        chk(prev_en && !strobe_en, "R7 release together", strobe_en, 0);
        last_burst = burst_refs;
        bursts_done++;
      end
      if (strobe_en && !prev_en) burst_refs = 0;
      if (prev_ras && !ras_n) begin
        chk(cas_low_run == E_CSR, "R3 CAS setup", cas_low_run, E_CSR);
        if (burst_refs > 0) chk(ras_high_run == E_PRE + E_CSR, "R4 RAS high", ras_high_run, E_PRE + E_CSR);
        refs++;
        burst_refs++;
        cas_in_ras = 0;
      end
      if (!prev_cas && cas_n && !ras_n) chk(cas_in_ras == E_CHR, "R3 CAS hold", cas_in_ras, E_CHR);
      if (!prev_ras && ras_n) chk(ras_low_run == E_RAS, "R4 RAS low", ras_low_run, E_RAS);
      if (init_done && !prev_init) begin
        chk(refs == INITN, "R8 init refreshes", refs, INITN);
        chk(!prev_ras && ras_n, "R8 init at RAS rise", ras_n, 1);
        chk(burst_refs == INITN, "R8 init burst", burst_refs, INITN);
      end
      // run lengths including this sample
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = (ras_n && !prev_ras) ? 1 : (ras_n ? ras_high_run + 1 : 0);
      if (!ras_n && !cas_n) cas_in_ras++;
      prev_ras = ras_n; prev_cas = cas_n; prev_req = ref_req;
      prev_en = strobe_en; prev_init = init_done;
      // sequencer: grant two samples after a request, withdraw once released
      if (ref_gnt && !ref_req) begin
        ref_gnt = 1'b0;
        gdly = 0;
      end else if (!ref_gnt && ref_req && allow) begin
        gdly++;
        if (gdly >= 2) ref_gnt = 1'b1;
      end else if (!ref_gnt) begin
        gdly = 0;
      end
    end
  end

  initial begin
    int r0;
    int b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wait (init_done);
    repeat (300) @(negedge clk);
    // R9: steady rate with a prompt grant
    r0 = refs;
    b0 = bursts_done;
    repeat (10 * E_INT) @(negedge clk);
    chk((refs - r0) >= 9 && (refs - r0) <= 11, "R9 refresh rate", refs - r0, 10);
    chk((bursts_done - b0) == (refs - r0), "R9 one per burst", bursts_done - b0, refs - r0);
    // R10: three missed intervals
    wait (!ref_req);
    @(negedge clk);
    allow = 1'b0;
    wait (ref_req);
    repeat (2 * E_INT + 50) @(negedge clk);
    b0 = bursts_done;
    allow = 1'b1;
    wait (bursts_done > b0);
    chk(last_burst == 3, "R10 backlog served", last_burst, 3);
    // R10: cap on the backlog
    @(negedge clk);
    allow = 1'b0;
    wait (ref_req);
    repeat (11 * E_INT + 50) @(negedge clk);
    b0 = bursts_done;
    allow = 1'b1;
    wait (bursts_done > b0);
    chk(last_burst == BMAX, "R10 backlog cap", last_burst, BMAX);
    repeat (2 * E_INT) @(negedge clk);
    chk(bursts_done > b0 + 1, "R9 resumes after backlog", bursts_done - b0, 2);
    done_flag = 1'b1;
  end

  initial begin
    int wd = 0;
    while (!done_flag && wd < 60000) begin
      @(negedge clk);
      wd++;
    end
    if (!done_flag) chk(1'b0, "watchdog", wd, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule